// File: doc/BRIEF.md
# Configuration Stream Integrity Checker

This block watches a stream of configuration register writes as it arrives and decides whether the stream can be trusted. Each write carries a register address and a 32-bit word. The block folds every accepted write into a running 16-bit CRC. When a write lands on the checksum register, the block compares the value carried in the stream against that running result. A separate write to the device identity register is compared against a constant identifier built into the block, which catches a stream that was built for another device.

Both error conditions are held in sticky flags, and either flag raises a restart indication. Once the identity check has failed, the block refuses further frame data writes through a reject output. A host-controlled option input skips the checksum comparison. A dedicated clear input returns the flags and the running CRC to zero. Packet header parsing is done upstream, so the block only sees already decoded address and data pairs.

Top module: `cfg_stream_checker`

## Requirements
- R1: The running CRC starts at zero and is advanced by every accepted write except checksum-register writes. Polynomial x^16+x^15+x^2+1 is used in reflected form 0xA001. The input is 37 bits processed LSB first: wr_data bit 0 through bit 31, then wr_addr bit 0 through bit 4.
- R2: A write to address 0 (the checksum register) with crc_bypass low compares wr_data[15:0] with the running CRC. On a match, the running CRC becomes zero and crc_err is left unchanged.
- R3: If that comparison fails, crc_err is set at the next clock edge and the running CRC keeps its value.
- R4: While crc_bypass is high, a checksum-register write never sets crc_err, and the running CRC becomes zero.
- R5: A write to address 12 (the identity register) is compared with the DEVICE_ID parameter. On a mismatch, id_mismatch is set at the next clock edge. The write is still folded into the CRC.
- R6: While id_mismatch is set, a write to address 2 (frame data) raises wr_reject combinationally in the same cycle, and that write does not advance the CRC.
- R7: crc_err and id_mismatch stay set until flags_clr is high at a clock edge. That edge clears both flags and the running CRC, and any write in the same cycle is ignored.
- R8: restart_req is high exactly when crc_err or id_mismatch is high.
- R9: After rst_n is asserted, all flags and wr_reject are low and the running CRC is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A register write is present this cycle |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 32 | Data word of the write |
| crc_bypass | input | 1 | Skip the checksum comparison |
| flags_clr | input | 1 | Clear flags and running CRC |
| crc_err | output | 1 | Sticky checksum mismatch flag |
| id_mismatch | output | 1 | Sticky wrong-device flag |
| restart_req | output | 1 | Configuration must be repeated |
| wr_reject | output | 1 | Current frame data write refused |

## Verification
wr_reject is combinational, so the bench samples it 1 ns after driving the write, before the capturing edge. crc_err, id_mismatch and restart_req come from registers and change at the edge that captures the write. The bench therefore reads them at the following falling edge, one cycle after the stimulus. Inputs are always driven on falling edges, and the running CRC is tracked by a bit-serial model in the bench. This lets every checksum write be formed as an exact match or a deliberate one-bit miss.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

    typedef enum logic [2:0] {
        WK_NONE  = 3'd0,
        WK_CHECK = 3'd1,
        WK_DEVID = 3'd2,
        WK_FRAME = 3'd3,
        WK_OTHER = 3'd4
    } write_kind_e;

endpackage

// File: rtl/cfgchk_decode.sv
module cfgchk_decode #(
    parameter int          ADDR_W  = 5,
    parameter logic [4:0]  A_CHECK = 5'd0,
    parameter logic [4:0]  A_FRAME = 5'd2,
    parameter logic [4:0]  A_DEVID = 5'd12
) (
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    output cfgchk_pkg::write_kind_e    kind
);
    import cfgchk_pkg::*;

    always_comb begin
        if (!wr_valid)                          kind = WK_NONE;
        else if (wr_addr == ADDR_W'(A_CHECK))   kind = WK_CHECK;
        else if (wr_addr == ADDR_W'(A_DEVID))   kind = WK_DEVID;
        else if (wr_addr == ADDR_W'(A_FRAME))   kind = WK_FRAME;
        else                                    kind = WK_OTHER;
    end
endmodule

// File: rtl/cfgchk_crc_step.sv
module cfgchk_crc_step #(
    parameter int                DATA_W = 32,
    parameter int                ADDR_W = 5,
    parameter int                CRC_W  = 16,
    parameter logic [CRC_W-1:0]  POLY_R = 16'hA001
) (
    input  logic [CRC_W-1:0]   crc_in,
    input  logic [DATA_W-1:0]  data,
    input  logic [ADDR_W-1:0]  addr,
    output logic [CRC_W-1:0]   crc_out
);
    localparam int IN_W = DATA_W + ADDR_W;

    logic [IN_W-1:0]  stream;
    logic [CRC_W-1:0] chain [IN_W+1];

    assign stream   = {addr, data};
    assign chain[0] = crc_in;

    for (genvar i = 0; i < IN_W; i++) begin : g_bit
        assign chain[i+1] = (chain[i] >> 1)
                          ^ ((chain[i][0] ^ stream[i]) ? POLY_R : '0);
    end

    assign crc_out = chain[IN_W];
endmodule

// File: rtl/cfgchk_id_cmp.sv
module cfgchk_id_cmp #(
    parameter int                 ID_W      = 32,
    parameter logic [ID_W-1:0]    DEVICE_ID = 32'h1A2B_3C4D
) (
    input  logic            hit,
    input  logic [ID_W-1:0] word,
    output logic            bad
);
    assign bad = hit && (word != DEVICE_ID);
endmodule

// File: rtl/cfg_stream_checker.sv
module cfg_stream_checker #(
    parameter int                 DATA_W    = 32,
    parameter int                 ADDR_W    = 5,
    parameter int                 CRC_W     = 16,
    parameter logic [CRC_W-1:0]   POLY_R    = 16'hA001,
    parameter logic [DATA_W-1:0]  DEVICE_ID = 32'h1A2B_3C4D,
    parameter logic [4:0]         A_CHECK   = 5'd0,
    parameter logic [4:0]         A_FRAME   = 5'd2,
    parameter logic [4:0]         A_DEVID   = 5'd12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              crc_bypass,
    input  logic              flags_clr,
    output logic              crc_err,
    output logic              id_mismatch,
    output logic              restart_req,
    output logic              wr_reject
);
    import cfgchk_pkg::*;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             err;
        logic             idm;
    } chk_state_t;

    chk_state_t   st_d, st_q;
    write_kind_e  kind;
    logic [CRC_W-1:0] crc_next;
    logic         id_bad;
    logic         reject_d;

    cfgchk_decode #(
        .ADDR_W (ADDR_W), .A_CHECK(A_CHECK), .A_FRAME(A_FRAME), .A_DEVID(A_DEVID)
    ) u_decode (
        .wr_valid (wr_valid), .wr_addr (wr_addr), .kind (kind)
    );

    cfgchk_crc_step #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .CRC_W (CRC_W), .POLY_R (POLY_R)
    ) u_crc (
        .crc_in (st_q.crc), .data (wr_data), .addr (wr_addr), .crc_out (crc_next)
    );

    cfgchk_id_cmp #(
        .ID_W (DATA_W), .DEVICE_ID (DEVICE_ID)
    ) u_id (
        .hit (kind == WK_DEVID), .word (wr_data), .bad (id_bad)
    );

    always_comb begin
        st_d     = st_q;
        reject_d = 1'b0;
        if (flags_clr) begin
            st_d = '0;
        end else begin
            unique case (kind)
                WK_NONE: ;
                WK_CHECK: begin
                    if (crc_bypass)
                        st_d.crc = '0;
                    else if (wr_data[CRC_W-1:0] == st_q.crc)
                        st_d.crc = '0;
                    else
                        st_d.err = 1'b1;
                end
                WK_FRAME: begin
                    if (st_q.idm) reject_d = 1'b1;
                    else          st_d.crc = crc_next;
                end
                WK_DEVID: begin
                    st_d.crc = crc_next;
                    if (id_bad) st_d.idm = 1'b1;
                end
                default: st_d.crc = crc_next;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_err     = st_q.err;
    assign id_mismatch = st_q.idm;
    assign restart_req = st_q.err | st_q.idm;
    assign wr_reject   = reject_d;

    AST_MATCH_ZEROES_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_CHECK && !flags_clr && !crc_bypass && wr_data[CRC_W-1:0] == st_q.crc)
        |=> (st_q.crc == '0)); // R2
    AST_MISS_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_CHECK && !flags_clr && !crc_bypass && wr_data[CRC_W-1:0] != st_q.crc)
        |=> (crc_err && $stable(st_q.crc))); // R3
    AST_BYPASS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_CHECK && !flags_clr && crc_bypass && !crc_err) |=> !crc_err); // R4
    AST_REJECT_NEEDS_IDM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> (id_mismatch && wr_addr == ADDR_W'(A_FRAME))); // R6
    AST_REJECT_HOLDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> $stable(st_q.crc)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !flags_clr) |=> crc_err); // R7
    AST_IDM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mismatch && !flags_clr) |=> id_mismatch); // R7
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        flags_clr |=> (!crc_err && !id_mismatch && st_q.crc == '0)); // R7
endmodule

// File: tb/cfg_stream_checker_test.sv
`timescale 1ns/1ps
module cfg_stream_checker_test;
    localparam logic [31:0] DEV_ID = 32'h1A2B_3C4D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        crc_bypass = 1'b0;
    logic        flags_clr = 1'b0;
    logic        crc_err, id_mismatch, restart_req, wr_reject;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] model = '0;
    logic        id_model = 1'b0;

    always #4 clk = ~clk;

    cfg_stream_checker uut (
        .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_addr (wr_addr),
        .wr_data (wr_data), .crc_bypass (crc_bypass), .flags_clr (flags_clr),
        .crc_err (crc_err), .id_mismatch (id_mismatch),
        .restart_req (restart_req), .wr_reject (wr_reject)
    );

    function automatic logic [15:0] crc_ref(logic [15:0] c, logic [4:0] a, logic [31:0] d);
        logic [36:0] s = {a, d};
        for (int i = 0; i < 37; i++) begin
            logic fb = c[0] ^ s[i];
            c = c >> 1;
            if (fb) c = c ^ 16'hA001;
        end
        return c;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // op: 0 write, 1 checksum exact, 2 checksum off by one bit, 3 clear
    // fields: op[42:41] addr[40:36] data[35:4] bypass[3] err[2] idm[1] rej[0]
    localparam int NV = 20;
    localparam logic [42:0] VEC [NV] = '{
        {2'd0, 5'd1,  32'hAAAA5555, 1'b0, 3'b000},
        {2'd0, 5'd2,  32'h12345678, 1'b0, 3'b000},
        {2'd0, 5'd12, 32'h1A2B3C4D, 1'b0, 3'b000},
        {2'd0, 5'd2,  32'hDEADBEEF, 1'b0, 3'b000},
        {2'd1, 5'd0,  32'h0,        1'b0, 3'b000},
        {2'd0, 5'd2,  32'h0F0F0F0F, 1'b0, 3'b000},
        {2'd2, 5'd0,  32'h0,        1'b0, 3'b100},
        {2'd0, 5'd2,  32'h00000001, 1'b0, 3'b100},
        {2'd1, 5'd0,  32'h0,        1'b0, 3'b100},
        {2'd3, 5'd0,  32'h0,        1'b0, 3'b000},
        {2'd0, 5'd2,  32'hCAFEF00D, 1'b0, 3'b000},
        {2'd2, 5'd0,  32'h0,        1'b1, 3'b000},
        {2'd0, 5'd2,  32'h00000000, 1'b0, 3'b000},
        {2'd1, 5'd0,  32'h0,        1'b0, 3'b000},
        {2'd0, 5'd12, 32'h0BADBEEF, 1'b0, 3'b010},
        {2'd0, 5'd2,  32'h11111111, 1'b0, 3'b011},
        {2'd1, 5'd0,  32'h0,        1'b0, 3'b010},
        {2'd3, 5'd0,  32'h0,        1'b0, 3'b000},
        {2'd0, 5'd2,  32'h00000022, 1'b0, 3'b000},
        {2'd1, 5'd0,  32'h0,        1'b0, 3'b000}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R9 crc_err reset", crc_err, 1'b0);
        check("R9 id_mismatch reset", id_mismatch, 1'b0);
        check("R9 wr_reject reset", wr_reject, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op   = VEC[v][42:41];
            logic [4:0]  a    = VEC[v][40:36];
            logic [31:0] d    = VEC[v][35:4];
            logic        byp  = VEC[v][3];
            logic        e_err = VEC[v][2];
            logic        e_idm = VEC[v][1];
            logic        e_rej = VEC[v][0];
            string       etag;
            crc_bypass = byp;
            case (op)
                2'd0: begin wr_valid = 1'b1; wr_addr = a; wr_data = d; end
                2'd1: begin wr_valid = 1'b1; wr_addr = 5'd0; wr_data = {16'h0, model}; end
                2'd2: begin wr_valid = 1'b1; wr_addr = 5'd0; wr_data = {16'h0, model ^ 16'h0001}; end
                default: flags_clr = 1'b1;
            endcase
            #1;
            check("R6 wr_reject", wr_reject, e_rej);
            // reference update (R1 folding rules)
            case (op)
                2'd0: begin
                    if (!(a == 5'd2 && id_model)) model = crc_ref(model, a, d);
                    if (a == 5'd12 && d != DEV_ID) id_model = 1'b1;
                end
                2'd1: model = '0;
                2'd2: if (byp) model = '0;
                default: begin model = '0; id_model = 1'b0; end
            endcase
            @(posedge clk);
            @(negedge clk);
            wr_valid = 1'b0; flags_clr = 1'b0; crc_bypass = 1'b0;
            etag = (op == 2'd1) ? "R1 R2 crc_err" :
                   (op == 2'd3) ? "R7 crc_err"    :
                   (op == 2'd2 && byp) ? "R4 crc_err" : "R3 crc_err";
            check(etag, crc_err, e_err);
            check((op == 2'd3) ? "R7 id_mismatch" : "R5 id_mismatch", id_mismatch, e_idm);
            check("R8 restart_req", restart_req, e_err | e_idm);
        end

        // R7: clear wins over a simultaneous bad identity write
        wr_valid = 1'b1; wr_addr = 5'd12; wr_data = 32'h0; flags_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0; flags_clr = 1'b0;
        check("R7 clear priority id_mismatch", id_mismatch, 1'b0);
        // CRC must be zero: checksum 0 matches
        wr_valid = 1'b1; wr_addr = 5'd0; wr_data = 32'h0;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
        check("R7 crc zero after clear", crc_err, 1'b0);

        // R9: reset in mid-run clears sticky state
        wr_valid = 1'b1; wr_addr = 5'd12; wr_data = 32'h5;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
        check("R5 id set before reset", id_mismatch, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R9 id_mismatch after reset", id_mismatch, 1'b0);
        check("R9 restart_req after reset", restart_req, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        wr_valid = 1'b1; wr_addr = 5'd0; wr_data = 32'h0;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
        check("R9 crc zero after reset", crc_err, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule